// File: doc/BRIEF.md
# Color Channel Rotation Sequencer

This block sits between the serial-loaded control registers and the pixel conversion path of a linear image-sensor front end. On each conversion it decides which analog input (red, green or blue) feeds the converter. Separately, it decides which of the three stored gain/offset sets is applied. The choice follows a 2-bit configuration code: one fixed channel, a rotating gain/offset set on a single input, all three inputs rotating per pixel, or all three rotating once per scan line.

The block also delays the raw conversion codes through a pipeline. The length of that pipeline depends on the configuration. Codes can be complemented for sensors whose signal falls as light increases. The resulting code, an output-enable for the external tri-state bus and a data-valid flag are driven out. The converter clock arrives as two single-cycle strobes in the system clock domain: one marks its falling edge (a pixel conversion) and one marks its rising edge.

Top module: `color_rot_seq`

## Requirements
- R1: With configuration code 0, `in_sel` is 0 (red) and the gain/offset outputs carry the red set at all times, whatever the strobes do. Channel codes are 0 red, 1 green, 2 blue.
- R2: With configuration code 1, `in_sel` stays 0. The gain/offset set steps red, green, blue, red on each `sample_fall` strobe.
- R3: With configuration code 2, the input and the gain/offset set step together red, green, blue on each `sample_fall`. `grab_all` is high during a `sample_fall` cycle whose selected channel is red, so all three inputs are held together every third pixel.
- R4: With configuration code 3, input and gain/offset stay fixed within a line and advance one color on each rising edge of `line_start`. A configuration write (`cfg_wr`) of code 3 returns the line color to red.
- R5: While `line_start` is high, the per-pixel rotation index returns to red, even when a `sample_fall` falls in the same cycle, and `bus_oe` is low.
- R6: A code presented with `sample_fall` number n is driven on `bus_q` after strobe n+8 in configurations 0 and 3, and after strobe n+6 in configurations 1 and 2.
- R7: `data_valid` rises in the cycle after a `sample_fall` and falls in the cycle after a `sample_rise`.
- R8: After reset or any `cfg_wr`, `data_valid` stays low for the first L strobes, where L is the latency of R6.
- R9: With `invert` high at the output strobe, `bus_q` is the bitwise complement of the delayed code.
- R10: With `out_disable` high, `bus_oe` is low regardless of `line_start`.
- R11: After reset, the red input and red set are selected, `data_valid` is low, and `bus_oe` is high when neither `line_start` nor `out_disable` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_fall | input | 1 | Converter-clock falling-edge strobe (one pixel conversion) |
| sample_rise | input | 1 | Converter-clock rising-edge strobe |
| line_start | input | 1 | Line-start level |
| cfg | input | 2 | Signal configuration code 0..3 |
| cfg_wr | input | 1 | One-cycle pulse: configuration register written |
| invert | input | 1 | Complement output codes |
| out_disable | input | 1 | Force output bus to high impedance |
| gain_r | input | GAIN_W | Red gain code |
| gain_g | input | GAIN_W | Green gain code |
| gain_b | input | GAIN_W | Blue gain code |
| ofs_r | input | OFS_W | Red offset code |
| ofs_g | input | OFS_W | Green offset code |
| ofs_b | input | OFS_W | Blue offset code |
| raw_code | input | CODE_W | Raw conversion result |
| in_sel | output | 2 | Selected analog input channel |
| gain_sel | output | GAIN_W | Gain code for the next conversion |
| ofs_sel | output | OFS_W | Offset code for the next conversion |
| grab_all | output | 1 | Hold all three inputs together this pixel |
| bus_q | output | CODE_W | Delayed, optionally complemented code |
| bus_oe | output | 1 | Output bus drive enable |
| data_valid | output | 1 | `bus_q` holds a valid code |

## Verification
Two functions meet in one cycle here: the per-pixel channel advance and the line-start reset to red. In configuration 2 the bench raises `line_start` in the same cycle as a `sample_fall` that would otherwise move to the next color. The scoreboard then expects red, not the next color, on the following pixel. It also expects `grab_all` to follow the pre-strobe channel. The second collision is a line-start edge together with a configuration write of code 3. This is approached by checking that a write after several line advances lands on red, whatever color the line counter held.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } chan_e;

    typedef enum logic [1:0] {
        CFG_SINGLE     = 2'd0,
        CFG_SET_ROT    = 2'd1,
        CFG_TRIPLE_PIX = 2'd2,
        CFG_TRIPLE_LN  = 2'd3
    } cfg_e;

    typedef struct packed {
        chan_e in_sel;
        chan_e set_sel;
    } route_t;

    function automatic chan_e chan_next(chan_e c);
        case (c)
            CH_RED:  return CH_GRN;
            CH_GRN:  return CH_BLU;
            default: return CH_RED;
        endcase
    endfunction

    function automatic logic pixel_rotates(cfg_e m);
        return (m == CFG_SET_ROT) || (m == CFG_TRIPLE_PIX);
    endfunction

    function automatic logic lat_in_clocks(cfg_e m);
        return (m == CFG_SINGLE) || (m == CFG_TRIPLE_LN);
    endfunction

endpackage

// File: rtl/crs_chan_seq.sv
module crs_chan_seq
    import crs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cfg_e   cfg,
    input  logic   cfg_wr,
    input  logic   sample_fall,
    input  logic   line_start,
    output route_t route,
    output logic   grab_all
);

    chan_e pix_q;
    chan_e line_q;
    logic  ls_q;
    logic  line_rise;

    assign line_rise = line_start & ~ls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= CH_RED;
            line_q <= CH_RED;
            ls_q   <= 1'b0;
        end else begin
            ls_q <= line_start;
            if (cfg_wr || line_start)
                pix_q <= CH_RED;
            else if (sample_fall && pixel_rotates(cfg))
                pix_q <= chan_next(pix_q);
            if (cfg_wr && cfg == CFG_TRIPLE_LN)
                line_q <= CH_RED;
            else if (line_rise && cfg == CFG_TRIPLE_LN)
                line_q <= chan_next(line_q);
        end
    end

    always_comb begin
        case (cfg)
            CFG_SINGLE:     route = '{in_sel: CH_RED, set_sel: CH_RED};
            CFG_SET_ROT:    route = '{in_sel: CH_RED, set_sel: pix_q};
            CFG_TRIPLE_PIX: route = '{in_sel: pix_q,  set_sel: pix_q};
            default:        route = '{in_sel: line_q, set_sel: line_q};
        endcase
    end

    assign grab_all = sample_fall && (cfg == CFG_TRIPLE_PIX) && (pix_q == CH_RED);

    // R2 R3
    pix_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_fall && !line_start && !cfg_wr && pixel_rotates(cfg))
        |=> (pix_q != $past(pix_q)));

    // R5
    line_red_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (pix_q == CH_RED));

    // R4
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg == CFG_TRIPLE_LN && !cfg_wr && !line_rise) |=> $stable(line_q));

endmodule

// File: rtl/crs_code_pipe.sv
module crs_code_pipe
    import crs_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int LAT_CLK = 8,
    parameter int LAT_PIX = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_e              cfg,
    input  logic              cfg_wr,
    input  logic              sample_fall,
    input  logic              sample_rise,
    input  logic              invert,
    input  logic [CODE_W-1:0] raw_code,
    output logic [CODE_W-1:0] code_q,
    output logic              data_valid
);

    localparam int DEPTH = (LAT_CLK > LAT_PIX) ? LAT_CLK : LAT_PIX;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CODE_W-1:0] stage_q [DEPTH];
    logic [CODE_W-1:0] tap;
    logic [CNT_W-1:0]  lat;
    logic [CNT_W-1:0]  fill_q;
    logic              phase_q;
    logic              full_q;

    assign tap = lat_in_clocks(cfg) ? stage_q[LAT_CLK-1] : stage_q[LAT_PIX-1];
    assign lat = lat_in_clocks(cfg) ? CNT_W'(LAT_CLK) : CNT_W'(LAT_PIX);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else if (sample_fall) begin
            stage_q[0] <= raw_code;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            phase_q <= 1'b0;
        end else if (sample_fall) begin
            code_q  <= invert ? ~tap : tap;
            phase_q <= 1'b1;
        end else if (sample_rise) begin
            phase_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_wr) begin
            fill_q <= '0;
            full_q <= 1'b0;
        end else if (sample_fall) begin
            full_q <= (fill_q >= lat);
            if (fill_q < lat) fill_q <= fill_q + 1'b1;
        end
    end

    assign data_valid = phase_q & full_q;

    // R7
    rise_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_rise && !sample_fall) |=> !data_valid);

    // R8
    wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !data_valid);

endmodule

// File: rtl/color_rot_seq.sv
module color_rot_seq
    import crs_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int GAIN_W  = 6,
    parameter int OFS_W   = 8,
    parameter int LAT_CLK = 8,
    parameter int LAT_PIX = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_fall,
    input  logic              sample_rise,
    input  logic              line_start,
    input  logic [1:0]        cfg,
    input  logic              cfg_wr,
    input  logic              invert,
    input  logic              out_disable,
    input  logic [GAIN_W-1:0] gain_r,
    input  logic [GAIN_W-1:0] gain_g,
    input  logic [GAIN_W-1:0] gain_b,
    input  logic [OFS_W-1:0]  ofs_r,
    input  logic [OFS_W-1:0]  ofs_g,
    input  logic [OFS_W-1:0]  ofs_b,
    input  logic [CODE_W-1:0] raw_code,
    output logic [1:0]        in_sel,
    output logic [GAIN_W-1:0] gain_sel,
    output logic [OFS_W-1:0]  ofs_sel,
    output logic              grab_all,
    output logic [CODE_W-1:0] bus_q,
    output logic              bus_oe,
    output logic              data_valid
);

    cfg_e   mode;
    route_t route;

    assign mode = cfg_e'(cfg);

    crs_chan_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cfg         (mode),
        .cfg_wr      (cfg_wr),
        .sample_fall (sample_fall),
        .line_start  (line_start),
        .route       (route),
        .grab_all    (grab_all)
    );

    crs_code_pipe #(
        .CODE_W  (CODE_W),
        .LAT_CLK (LAT_CLK),
        .LAT_PIX (LAT_PIX)
    ) u_pipe (
        .clk         (clk),
        .rst         (rst),
        .cfg         (mode),
        .cfg_wr      (cfg_wr),
        .sample_fall (sample_fall),
        .sample_rise (sample_rise),
        .invert      (invert),
        .raw_code    (raw_code),
        .code_q      (bus_q),
        .data_valid  (data_valid)
    );

    always_comb begin
        case (route.set_sel)
            CH_GRN:  begin gain_sel = gain_g; ofs_sel = ofs_g; end
            CH_BLU:  begin gain_sel = gain_b; ofs_sel = ofs_b; end
            default: begin gain_sel = gain_r; ofs_sel = ofs_r; end
        endcase
    end

    assign in_sel = route.in_sel;
    assign bus_oe = !out_disable && !line_start;

    // R1
    single_red_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg == 2'd0) |-> (in_sel == 2'd0 && gain_sel == gain_r && ofs_sel == ofs_r));

endmodule

// File: tb/color_rot_seq_test.sv
module color_rot_seq_test;

    logic       clk = 0;
    logic       rst = 1;
    logic       sample_fall = 0, sample_rise = 0, line_start = 0;
    logic [1:0] cfg = 0;
    logic       cfg_wr = 0, invert = 0, out_disable = 0;
    logic [5:0] gain_r = 6'd5, gain_g = 6'd20, gain_b = 6'd47;
    logic [7:0] ofs_r = 8'h40, ofs_g = 8'h81, ofs_b = 8'hC3;
    logic [7:0] raw_code = 0;
    logic [1:0] in_sel;
    logic [5:0] gain_sel;
    logic [7:0] ofs_sel;
    logic       grab_all, bus_oe, data_valid;
    logic [7:0] bus_q;

    color_rot_seq uut (.*);

    always #10 clk = ~clk;

    typedef struct {
        int    code;
        bit    valid;
        int    insel;
        int    set;
    } exp_t;

    exp_t sb[$];
    int   hist[$];
    int   since_clear = 0;
    int   pix = 0;
    int   line_c = 0;
    int   checks = 0;
    int   errors = 0;
    logic strobe_seen = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gain_of(int s);
        return (s == 1) ? int'(gain_g) : (s == 2) ? int'(gain_b) : int'(gain_r);
    endfunction

    function automatic int ofs_of(int s);
        return (s == 1) ? int'(ofs_g) : (s == 2) ? int'(ofs_b) : int'(ofs_r);
    endfunction

    function automatic int lat_now();
        return (cfg == 0 || cfg == 3) ? 8 : 6;
    endfunction

    // driver: one pixel, with optional line start in the same cycle
    task automatic pixel(input int code, input bit ls_too);
        exp_t e;
        int   j;
        @(negedge clk);
        raw_code = code[7:0];
        sample_fall = 1;
        line_start = ls_too;
        #1;
        chk(grab_all == (cfg == 2 && pix == 0), "R3 grab_all", grab_all, (cfg == 2 && pix == 0));
        j = since_clear;
        e.valid = (j >= lat_now());
        e.code = e.valid ? ((hist[j - lat_now()] ^ (invert ? 255 : 0)) & 255) : 0;
        hist.push_back(code);
        since_clear++;
        if (ls_too) pix = 0;
        else if (cfg == 1 || cfg == 2) pix = (pix + 1) % 3;
        case (cfg)
            2'd0: begin e.insel = 0;      e.set = 0;      end
            2'd1: begin e.insel = 0;      e.set = pix;    end
            2'd2: begin e.insel = pix;    e.set = pix;    end
            default: begin e.insel = line_c; e.set = line_c; end
        endcase
        sb.push_back(e);
        @(negedge clk);
        sample_fall = 0;
        line_start = 0;
        sample_rise = 1;
        @(negedge clk);
        sample_rise = 0;
        #1;
        chk(data_valid == 0, "R7 valid after rise", data_valid, 0);
    endtask

    task automatic write_cfg(input int c);
        @(negedge clk);
        cfg = c[1:0];
        cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
        since_clear = 0;
        hist.delete();
        pix = 0;
        if (c == 3) line_c = 0;
    endtask

    task automatic line_pulse();
        @(negedge clk);
        line_start = 1;
        #1;
        chk(bus_oe == 0, "R5 bus_oe during line start", bus_oe, 0);
        @(negedge clk);
        line_start = 0;
        pix = 0;
        if (cfg == 3) line_c = (line_c + 1) % 3;
        @(negedge clk);
        #1;
        chk(in_sel == line_c[1:0] || cfg != 3, "R4 line color", in_sel, line_c);
    endtask

    // monitor
    always @(posedge clk) strobe_seen <= sample_fall;

    always @(negedge clk) begin
        if (strobe_seen && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(data_valid == e.valid, "R8 data_valid fill", data_valid, e.valid);
            if (e.valid)
                chk(int'(bus_q) == e.code, invert ? "R9 inverted code" : "R6 delayed code",
                    bus_q, e.code);
            chk(int'(in_sel) == e.insel, "R1 R2 R3 R4 input select", in_sel, e.insel);
            chk(int'(gain_sel) == gain_of(e.set), "R2 gain set", gain_sel, gain_of(e.set));
            chk(int'(ofs_sel) == ofs_of(e.set), "R2 offset set", ofs_sel, ofs_of(e.set));
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        // R11
        chk(in_sel == 0, "R11 reset in_sel", in_sel, 0);
        chk(data_valid == 0, "R11 reset valid", data_valid, 0);
        chk(gain_sel == gain_r, "R11 reset gain", gain_sel, gain_r);
        chk(bus_oe == 1, "R11 reset bus_oe", bus_oe, 1);

        // R1 R6: single channel, 8-strobe latency
        for (int i = 0; i < 12; i++) pixel(10 + i * 7, 0);

        // R3 R5 R6: triple per pixel, line start collides with a strobe
        write_cfg(2);
        for (int i = 0; i < 10; i++) pixel(200 - i * 9, i == 4);

        // R2 R9: gain set rotation, then inverted codes
        write_cfg(1);
        for (int i = 0; i < 7; i++) pixel(3 + i * 11, 0);
        @(negedge clk);
        invert = 1;
        for (int i = 0; i < 4; i++) pixel(90 + i * 5, 0);
        @(negedge clk);
        invert = 0;

        // R4: per-line rotation
        write_cfg(3);
        #1;
        chk(in_sel == 0, "R4 write resets to red", in_sel, 0);
        for (int i = 0; i < 10; i++) pixel(i * 17, 0);
        line_pulse();
        for (int i = 0; i < 3; i++) pixel(50 + i, 0);
        line_pulse();
        line_pulse();
        line_pulse();
        write_cfg(3);
        #1;
        chk(in_sel == 0, "R4 rewrite resets to red", in_sel, 0);

        // R10
        @(negedge clk);
        out_disable = 1;
        #1;
        chk(bus_oe == 0, "R10 output disable", bus_oe, 0);
        @(negedge clk);
        out_disable = 0;
        #1;
        chk(bus_oe == 1, "R10 output re-enabled", bus_oe, 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule